// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is the pin-level part of a boundary scan port. It puts one scan cell behind every chip input pin. Each output pin gets two cells: one for its data and one for its output enable. All of these cells are linked into a single serial register that runs from a scan input to a scan output. The TAP state machine and the instruction decoder live elsewhere. They drive this block through three strobes (capture, shift, update) and a few mode selects.

Each cell has two stages.

- The capture stage takes a snapshot of the live pin or core value. It then moves that value along the chain one cell per test clock.
- The separate hold stage copies the capture stage only on the update strobe.

Because of this split, bits travelling down the chain never reach the pins or the core. Depending on the mode selects, the block does one of three things:

- passes functional signals straight through;
- drives the output pins and their enables from the hold stages (external test);
- drives the core inputs from the hold stages (internal test).

A separate force input floats every output regardless of mode. Everything runs on the test clock, and the strobes act as clock enables.

Top module: `bsc_chain`

## Requirements
- R1: The chain holds NUM_IN + 2*NUM_OUT cells. Cell 0 is nearest the scan input. Cells 0..NUM_IN-1 belong to input pins 0..NUM_IN-1. For output pin j, cell NUM_IN+2j holds its data and cell NUM_IN+2j+1 holds its enable. The last cell is nearest the scan output.
- R2: On a clock with captureDr high, each capture stage loads its live value: pinIn[i] for input cells, coreOut[j] for data cells and coreOe[j] for enable cells. This holds in every mode. When captureDr and shiftDr are both high, capture wins.
- R3: On a clock with shiftDr high and captureDr low, cell 0 loads scanIn and every other cell loads its neighbour nearer the input. scanOut always shows the capture stage of the last cell.
- R4: A hold stage changes only on a clock with updateDr high, where it loads its own capture stage. Capture and shift clocks never change pinOut, pinOe or coreIn.
- R5: With modeExtest and modeIntest both low, coreIn equals pinIn, pinOut equals coreOut and pinOe equals coreOe (when forceHighZ is low).
- R6: With modeExtest high, pinOut[j] and pinOe[j] come from the hold stages of the data and enable cells of output pin j.
- R7: With modeIntest high, coreIn[i] comes from the hold stage of input cell i. Otherwise it equals pinIn[i].
- R8: With forceHighZ high, every bit of pinOe is 0 whatever the other modes and hold values are.
- R9: While testRstN is low, every capture and hold stage is 0, so scanOut is 0. Under modeExtest, pinOut and pinOe are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| testClk | input | 1 | Test clock for every stage |
| testRstN | input | 1 | Asynchronous active-low reset of all stages |
| captureDr | input | 1 | Capture strobe (clock enable) |
| shiftDr | input | 1 | Shift strobe (clock enable) |
| updateDr | input | 1 | Update strobe, loads hold stages |
| scanIn | input | 1 | Serial data into cell 0 |
| modeExtest | input | 1 | Drive output pins and enables from hold stages |
| modeIntest | input | 1 | Drive core inputs from hold stages |
| forceHighZ | input | 1 | Force every output enable off |
| pinIn | input | NUM_IN | Values arriving at the input pins |
| coreOut | input | NUM_OUT | Output data from core logic |
| coreOe | input | NUM_OUT | Output enables from core logic |
| scanOut | output | 1 | Capture stage of the last cell |
| coreIn | output | NUM_IN | Values delivered to the core inputs |
| pinOut | output | NUM_OUT | Values driven onto the output pins |
| pinOe | output | NUM_OUT | Output enables of the output pins |

## Verification
The bench shifts a new pattern through the chain while external test is active and watches pinOut every cycle. A design without a separate hold stage would show the moving bits on the pins at once. Capture is checked on its own and with shift asserted in the same cycle. A design that let shift win would return a shifted pattern instead of the snapshot. The serial path is read back bit for bit, so an off-by-one in chain length or a cell order that differs from R1 shows up as a rotated or swapped word. The high-Z override is tested against hold enables that are all ones and core enables that are all ones. A design that gated only one source would leave some pin enabled.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic drivePins;
    logic driveCore;
    logic floatAll;
  } bsc_ctrl_t;
endpackage

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
  import bsc_pkg::*;
(
  input  logic      captureDr,
  input  logic      shiftDr,
  input  logic      updateDr,
  input  logic      modeExtest,
  input  logic      modeIntest,
  input  logic      forceHighZ,
  output bsc_ctrl_t ctrl
);
  always_comb begin
    ctrl.capture   = captureDr;
    ctrl.shift     = shiftDr & ~captureDr;
    ctrl.update    = updateDr;
    ctrl.drivePins = modeExtest;
    ctrl.driveCore = modeIntest;
    ctrl.floatAll  = forceHighZ;
  end
endmodule

// File: rtl/bsc_cell.sv
module bsc_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic parallelIn,
  input  logic serialIn,
  output logic capQ,
  output logic holdQ
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capQ <= 1'b0;
    else if (capture) capQ <= parallelIn;
    else if (shift) capQ <= serialIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) holdQ <= 1'b0;
    else if (update) holdQ <= capQ;
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(holdQ)); // R4
  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> capQ == $past(parallelIn)); // R2
endmodule

// File: rtl/bsc_datapath.sv
module bsc_datapath
  import bsc_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bsc_ctrl_t          ctrl,
  input  logic               scanIn,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic               scanOut,
  output logic [NUM_IN-1:0]  coreIn,
  output logic [NUM_OUT-1:0] pinOut,
  output logic [NUM_OUT-1:0] pinOe
);
  localparam int LEN = NUM_IN + 2 * NUM_OUT;

  logic [LEN-1:0] capVal;
  logic [LEN-1:0] serialSrc;
  logic [LEN-1:0] capQ;
  logic [LEN-1:0] holdQ;

  assign serialSrc = {capQ[LEN-2:0], scanIn};
  assign scanOut   = capQ[LEN-1];

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      assign capVal[i] = pinIn[i];
      assign coreIn[i] = ctrl.driveCore ? holdQ[i] : pinIn[i];
    end
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
      localparam int DATA_IDX = NUM_IN + 2 * j;
      localparam int EN_IDX   = DATA_IDX + 1;
      assign capVal[DATA_IDX] = coreOut[j];
      assign capVal[EN_IDX]   = coreOe[j];
      assign pinOut[j] = ctrl.drivePins ? holdQ[DATA_IDX] : coreOut[j];
      assign pinOe[j]  = ~ctrl.floatAll &
                         (ctrl.drivePins ? holdQ[EN_IDX] : coreOe[j]);
    end
    for (genvar k = 0; k < LEN; k++) begin : g_cell
      bsc_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (ctrl.capture),
        .shift     (ctrl.shift),
        .update    (ctrl.update),
        .parallelIn(capVal[k]),
        .serialIn  (serialSrc[k]),
        .capQ      (capQ[k]),
        .holdQ     (holdQ[k])
      );
    end
  endgenerate

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.shift |=> capQ == {$past(capQ[LEN-2:0]), $past(scanIn)}); // R3
  AST_SHIFT_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.shift && ctrl.drivePins && $stable(ctrl.drivePins)) |=> $stable(pinOut)); // R4
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               testClk,
  input  logic               testRstN,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic               scanIn,
  input  logic               modeExtest,
  input  logic               modeIntest,
  input  logic               forceHighZ,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic               scanOut,
  output logic [NUM_IN-1:0]  coreIn,
  output logic [NUM_OUT-1:0] pinOut,
  output logic [NUM_OUT-1:0] pinOe
);
  bsc_ctrl_t ctrl;

  bsc_ctrl u_ctrl (
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .modeExtest(modeExtest),
    .modeIntest(modeIntest),
    .forceHighZ(forceHighZ),
    .ctrl      (ctrl)
  );

  bsc_datapath #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_dp (
    .clk    (testClk),
    .rst_n  (testRstN),
    .ctrl   (ctrl),
    .scanIn (scanIn),
    .pinIn  (pinIn),
    .coreOut(coreOut),
    .coreOe (coreOe),
    .scanOut(scanOut),
    .coreIn (coreIn),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );

  AST_HIZ_FLOAT: assert property (@(posedge testClk) disable iff (!testRstN)
    forceHighZ |-> pinOe == '0); // R8
  AST_PASS_CORE: assert property (@(posedge testClk) disable iff (!testRstN)
    !modeIntest |-> coreIn == pinIn); // R7
  AST_PASS_PIN: assert property (@(posedge testClk) disable iff (!testRstN)
    !modeExtest |-> pinOut == coreOut); // R5
endmodule

// File: tb/bsc_chain_tb.sv
module bsc_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int LEN = NI + 2 * NO;

  // fields: [26] ext, [25] int, [24] hiz, [23:20] pinIn, [19:16] coreOut,
  //         [15:12] coreOe, [11:0] hold pattern
  localparam logic [26:0] VEC [4] = '{
    {3'b000, 4'b1010, 4'b0110, 4'b1100, 12'hA5C},
    {3'b100, 4'b0011, 4'b1111, 4'b0000, 12'h3C9},
    {3'b010, 4'b1111, 4'b0001, 4'b1111, 12'h6A5},
    {3'b111, 4'b0101, 4'b1010, 4'b1111, 12'hFFF}
  };

  logic clk = 0, rstN = 0;
  logic captureDr = 0, shiftDr = 0, updateDr = 0, scanIn = 0;
  logic modeExtest = 0, modeIntest = 0, forceHighZ = 0;
  logic [NI-1:0] pinIn = '0;
  logic [NO-1:0] coreOut = '0, coreOe = '0;
  logic scanOut;
  logic [NI-1:0] coreIn;
  logic [NO-1:0] pinOut, pinOe;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsc_chain #(.NUM_IN(NI), .NUM_OUT(NO)) u_dut (
    .testClk(clk), .testRstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .scanIn(scanIn), .modeExtest(modeExtest),
    .modeIntest(modeIntest), .forceHighZ(forceHighZ), .pinIn(pinIn),
    .coreOut(coreOut), .coreOe(coreOe), .scanOut(scanOut), .coreIn(coreIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [NI-1:0] holdIn(input logic [LEN-1:0] h);
    for (int i = 0; i < NI; i++) holdIn[i] = h[i];
  endfunction
  function automatic logic [NO-1:0] holdData(input logic [LEN-1:0] h);
    for (int j = 0; j < NO; j++) holdData[j] = h[NI + 2*j];
  endfunction
  function automatic logic [NO-1:0] holdEn(input logic [LEN-1:0] h);
    for (int j = 0; j < NO; j++) holdEn[j] = h[NI + 2*j + 1];
  endfunction
  function automatic logic [LEN-1:0] snap(input logic [NI-1:0] pi,
      input logic [NO-1:0] co, input logic [NO-1:0] oe);
    for (int i = 0; i < NI; i++) snap[i] = pi[i];
    for (int j = 0; j < NO; j++) begin
      snap[NI + 2*j] = co[j];
      snap[NI + 2*j + 1] = oe[j];
    end
  endfunction

  task automatic shiftIn(input logic [LEN-1:0] v);
    for (int s = 0; s < LEN; s++) begin
      shiftDr = 1; scanIn = v[LEN-1-s];
      @(negedge clk);
    end
    shiftDr = 0; scanIn = 0;
  endtask

  task automatic doUpdate();
    updateDr = 1; @(negedge clk); updateDr = 0;
  endtask

  task automatic readOut(output logic [LEN-1:0] r);
    for (int s = 0; s < LEN; s++) begin
      #1 r[LEN-1-s] = scanOut;
      shiftDr = 1;
      @(negedge clk);
    end
    shiftDr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] r, h, e;
    // R9 reset state
    modeExtest = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R9 scanOut", 32'(scanOut), 0);
    check("R9 pinOut", 32'(pinOut), 0);
    check("R9 pinOe", 32'(pinOe), 0);
    rstN = 1;
    modeExtest = 0;
    @(negedge clk);

    // table walk: R5 R6 R7 R8
    foreach (VEC[n]) begin
      h = VEC[n][11:0];
      shiftIn(h);
      doUpdate();
      modeExtest = VEC[n][26]; modeIntest = VEC[n][25]; forceHighZ = VEC[n][24];
      pinIn = VEC[n][23:20]; coreOut = VEC[n][19:16]; coreOe = VEC[n][15:12];
      #1;
      check("R7/R5 coreIn", 32'(coreIn), 32'(modeIntest ? holdIn(h) : pinIn));
      check("R6/R5 pinOut", 32'(pinOut), 32'(modeExtest ? holdData(h) : coreOut));
      check("R8/R6 pinOe", 32'(pinOe),
            32'(forceHighZ ? 4'b0 : (modeExtest ? holdEn(h) : coreOe)));
      @(negedge clk);
      modeExtest = 0; modeIntest = 0; forceHighZ = 0;
    end

    // R3 serial path: shift in a pattern, shift it back out
    shiftIn(12'hB36);
    readOut(r);
    check("R3 serial loop", 32'(r), 32'h00000B36);
    check("R1 chain length", 32'(scanOut), 32'(1'b0));

    // R2 capture snapshot with cell ordering R1
    pinIn = 4'b1001; coreOut = 4'b0110; coreOe = 4'b1011;
    captureDr = 1; @(negedge clk); captureDr = 0;
    readOut(r);
    check("R2 R1 capture snapshot", 32'(r), 32'(snap(4'b1001, 4'b0110, 4'b1011)));

    // R2 capture wins over shift
    pinIn = 4'b0110; coreOut = 4'b1100; coreOe = 4'b0101;
    captureDr = 1; shiftDr = 1; scanIn = 1; @(negedge clk);
    captureDr = 0; shiftDr = 0; scanIn = 0;
    readOut(r);
    check("R2 capture priority", 32'(r), 32'(snap(4'b0110, 4'b1100, 4'b0101)));

    // R4 shifting and capturing never disturb pins in extest
    h = 12'h5A3;
    shiftIn(h); doUpdate();
    modeExtest = 1; modeIntest = 1;
    e = ~h;
    for (int s = 0; s < LEN; s++) begin
      shiftDr = 1; scanIn = e[LEN-1-s];
      @(negedge clk); #1;
      if (pinOut !== holdData(h) || coreIn !== holdIn(h))
        check("R4 shift during extest", 32'({pinOut, coreIn}), 32'({holdData(h), holdIn(h)}));
    end
    shiftDr = 0;
    check("R4 pins held after shift", 32'(pinOut), 32'(holdData(h)));
    check("R4 enables held after shift", 32'(pinOe), 32'(holdEn(h)));
    captureDr = 1; @(negedge clk); captureDr = 0; #1;
    check("R4 core held after capture", 32'(coreIn), 32'(holdIn(h)));
    shiftIn(e);
    doUpdate(); #1;
    check("R4 update applies", 32'(pinOut), 32'(holdData(e)));
    check("R7 update core", 32'(coreIn), 32'(holdIn(e)));

    // R8 override with all enables high from both sources
    shiftIn(12'hFFF); doUpdate();
    forceHighZ = 1; #1;
    check("R8 hold enables forced off", 32'(pinOe), 0);
    modeExtest = 0; coreOe = 4'hF; #1;
    check("R8 core enables forced off", 32'(pinOe), 0);
    forceHighZ = 0; #1;
    check("R5 core enables pass", 32'(pinOe), 32'hF);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule